// File: doc/BRIEF.md
# Dual-Plane Voltage Reference Sequencer

This block drives two reference codes into the DACs of a two-rail regulator. One code is for the core rail and one is for the northbridge rail. When `enable` rises, the block captures a 2-bit boot selection into a holding register. It then ramps both references up from zero to the boot level together, one LSB per tick. At the end of the ramp it raises `pgood`.

Once `pgood` is high and the host raises `pwr_ok`, the block accepts set-voltage commands that are already decoded. Each command names the core rail, the northbridge rail or both, and gives a target code and an off flag. Each selected rail then steps toward its new target. When `pwr_ok` falls, both rails step back to the stored boot level, and command input is ignored until `pwr_ok` returns. Dropping `enable` clears everything synchronously.

The codes are 8 bits wide at 12.5 mV per LSB, where code 0 is 0 V. The controller has five states, and the states and transitions below are the whole control flow:
- IDLE → SOFTSTART: taken when `enable` is high. The boot code is captured on this transition.
- SOFTSTART → BOOTHOLD: taken when both references equal the boot code.
- BOOTHOLD → ACTIVE: taken when `pwr_ok` is high.
- ACTIVE → RETREAT: taken when `pwr_ok` is low.
- RETREAT → ACTIVE: taken when `pwr_ok` is high.
- Any state → IDLE: taken whenever `enable` is low at a clock edge.

Top module: `vref_sequencer`

## Requirements
- R1: One clock edge after `enable` is sampled low (or during reset), both references read 0 and `pgood` is 0.
- R2: The boot selection is captured when the block leaves IDLE. The mapping is 00→88 (1.1 V), 01→80 (1.0 V), 10→72 (0.9 V), 11→64 (0.8 V). Later changes of `boot_sel` have no effect.
- R3: A reference changes by at most one LSB per clock. Changes come from a tick that occurs every TICK_DIV clocks (default 16) while the block is out of IDLE.
- R4: `pgood` is low during soft-start. It rises one clock after both references first equal the boot code.
- R5: Commands are ignored until `pgood` and `pwr_ok` are both high. Until the first accepted command, both rails hold the boot level.
- R6: An accepted command (`cmd_valid` with `pwr_ok` high in ACTIVE) retargets only the selected rails: `cmd_core` selects the core rail and `cmd_nb` selects the northbridge rail. Each selected rail steps toward `cmd_code`.
- R7: With `cmd_off` set, a selected core rail targets code 0, and a selected northbridge rail still takes `cmd_code`. `pgood` stays high.
- R8: While `pwr_ok` is low after `pgood`, both rails target the boot code and all command inputs are ignored.
- R9: When `pwr_ok` returns, the rails hold the boot level until a new command arrives.
- R10: A command that arrives mid-ramp retargets from the current code at once, without first reaching the earlier target.
- R11: Once high, `pgood` stays high for as long as `enable` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Start request; low forces IDLE |
| boot_sel | input | 2 | Boot level selection, captured on leaving IDLE |
| pwr_ok | input | 1 | Host power-ok handshake |
| cmd_valid | input | 1 | One-cycle strobe of a decoded command |
| cmd_core | input | 1 | Command selects the core rail |
| cmd_nb | input | 1 | Command selects the northbridge rail |
| cmd_off | input | 1 | Command turns the core rail off |
| cmd_code | input | CODE_W | Command target code |
| core_ref | output | CODE_W | Core rail DAC code |
| nb_ref | output | CODE_W | Northbridge rail DAC code |
| pgood | output | 1 | Power-good |

## Verification
The assertions check four properties on every cycle:
- each reference moves by at most one LSB per clock;
- a low `enable` clears both codes and `pgood` on the next edge;
- `pgood` rises only with both codes at the boot level and then holds while enabled;
- with `pwr_ok` low, both targets sit at the boot code.

The bench scenarios cover what needs a history to judge:
- the exact boot mapping and that later `boot_sel` changes are ignored;
- tick spacing;
- which rail a command moves, including the off flag;
- the return to boot and the hold after `pwr_ok` returns;
- the immediate reversal on a mid-ramp retarget.

// File: rtl/vref_seq_pkg.sv
package vref_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SOFTSTART,
        ST_BOOTHOLD,
        ST_ACTIVE,
        ST_RETREAT
    } seq_state_t;

    localparam int NUM_PLANES = 2;
    localparam int PLANE_CORE = 0;
    localparam int PLANE_NB   = 1;

endpackage

// File: rtl/vref_tick_gen.sv
module vref_tick_gen #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/vref_boot_hold.sv
module vref_boot_hold #(
    parameter int CODE_W = 8,
    parameter int LVL_00 = 88,
    parameter int LVL_01 = 80,
    parameter int LVL_10 = 72,
    parameter int LVL_11 = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [1:0]        sel,
    output logic [CODE_W-1:0] level
);
    logic [CODE_W-1:0] decoded;

    always_comb begin
        unique case (sel)
            2'b00: decoded = CODE_W'(LVL_00);
            2'b01: decoded = CODE_W'(LVL_01);
            2'b10: decoded = CODE_W'(LVL_10);
            default: decoded = CODE_W'(LVL_11);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= CODE_W'(LVL_00);
        end else if (capture) begin
            level <= decoded;
        end
    end
endmodule

// File: rtl/vref_ramp.sv
module vref_ramp #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              tick,
    input  logic [CODE_W-1:0] target,
    output logic [CODE_W-1:0] level
);
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            level <= '0;
        end else if (tick) begin
            if (level < target) begin
                level <= level + 1'b1;
            end else if (level > target) begin
                level <= level - 1'b1;
            end
        end
    end
endmodule

// File: rtl/vref_sequencer.sv
module vref_sequencer
    import vref_seq_pkg::*;
#(
    parameter int CODE_W   = 8,
    parameter int TICK_DIV = 16,
    parameter int LVL_00   = 88,
    parameter int LVL_01   = 80,
    parameter int LVL_10   = 72,
    parameter int LVL_11   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [1:0]        boot_sel,
    input  logic              pwr_ok,
    input  logic              cmd_valid,
    input  logic              cmd_core,
    input  logic              cmd_nb,
    input  logic              cmd_off,
    input  logic [CODE_W-1:0] cmd_code,
    output logic [CODE_W-1:0] core_ref,
    output logic [CODE_W-1:0] nb_ref,
    output logic              pgood
);
    seq_state_t        state, nxt;
    logic [CODE_W-1:0] boot_lvl;
    logic [CODE_W-1:0] cmd_tgt   [NUM_PLANES];
    logic [CODE_W-1:0] plane_tgt [NUM_PLANES];
    logic [CODE_W-1:0] plane_ref [NUM_PLANES];
    logic              tick;
    logic              ramp_clear;
    logic              capture;
    logic              accept;

    assign capture    = (state == ST_IDLE) && enable;
    assign ramp_clear = (state == ST_IDLE) || !enable;
    assign accept     = (state == ST_ACTIVE) && cmd_valid && pwr_ok;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      nxt = ST_SOFTSTART;
            ST_SOFTSTART: if (plane_ref[PLANE_CORE] == boot_lvl &&
                              plane_ref[PLANE_NB] == boot_lvl) nxt = ST_BOOTHOLD;
            ST_BOOTHOLD:  if (pwr_ok)  nxt = ST_ACTIVE;
            ST_ACTIVE:    if (!pwr_ok) nxt = ST_RETREAT;
            ST_RETREAT:   if (pwr_ok)  nxt = ST_ACTIVE;
            default:      nxt = ST_IDLE;
        endcase
    end

    // Command targets: reloaded with boot level outside ACTIVE
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_tgt[PLANE_CORE] <= '0;
            cmd_tgt[PLANE_NB]   <= '0;
        end else if (state != ST_ACTIVE) begin
            cmd_tgt[PLANE_CORE] <= boot_lvl;
            cmd_tgt[PLANE_NB]   <= boot_lvl;
        end else if (accept) begin
            if (cmd_core) cmd_tgt[PLANE_CORE] <= cmd_off ? '0 : cmd_code;
            if (cmd_nb)   cmd_tgt[PLANE_NB]   <= cmd_code;
        end
    end

    // Outputs
    always_comb begin
        pgood = (state == ST_BOOTHOLD) || (state == ST_ACTIVE) || (state == ST_RETREAT);
        for (int p = 0; p < NUM_PLANES; p++) begin
            plane_tgt[p] = (state == ST_ACTIVE) ? cmd_tgt[p] : boot_lvl;
        end
    end

    vref_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state != ST_IDLE),
        .tick (tick)
    );

    vref_boot_hold #(
        .CODE_W(CODE_W), .LVL_00(LVL_00), .LVL_01(LVL_01),
        .LVL_10(LVL_10), .LVL_11(LVL_11)
    ) u_boot (
        .clk    (clk),
        .rst_n  (rst_n),
        .capture(capture),
        .sel    (boot_sel),
        .level  (boot_lvl)
    );

    for (genvar g = 0; g < NUM_PLANES; g++) begin : g_plane
        vref_ramp #(.CODE_W(CODE_W)) u_ramp (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (ramp_clear),
            .tick  (tick),
            .target(plane_tgt[g]),
            .level (plane_ref[g])
        );
    end

    assign core_ref = plane_ref[PLANE_CORE];
    assign nb_ref   = plane_ref[PLANE_NB];
endmodule

// File: rtl/vref_sequencer_chk.sv
module vref_sequencer_chk #(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              pwr_ok,
    input logic              pgood,
    input logic [CODE_W-1:0] core_ref,
    input logic [CODE_W-1:0] nb_ref,
    input logic [CODE_W-1:0] core_tgt,
    input logic [CODE_W-1:0] nb_tgt,
    input logic [CODE_W-1:0] boot_lvl
);
    // R1
    enable_low_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (core_ref == '0 && nb_ref == '0 && !pgood));

    // R3
    core_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(enable) |-> (core_ref == $past(core_ref) ||
                           core_ref == CODE_W'($past(core_ref) + 1'b1) ||
                           core_ref == CODE_W'($past(core_ref) - 1'b1)));

    // R3
    nb_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(enable) |-> (nb_ref == $past(nb_ref) ||
                           nb_ref == CODE_W'($past(nb_ref) + 1'b1) ||
                           nb_ref == CODE_W'($past(nb_ref) - 1'b1)));

    // R4
    pgood_at_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pgood) |-> (core_ref == boot_lvl && nb_ref == boot_lvl));

    // R11
    pgood_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pgood && enable) |=> pgood);

    // R8
    pwrok_low_boot_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> (core_tgt == boot_lvl && nb_tgt == boot_lvl));
endmodule

bind vref_sequencer vref_sequencer_chk #(.CODE_W(CODE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .pwr_ok  (pwr_ok),
    .pgood   (pgood),
    .core_ref(core_ref),
    .nb_ref  (nb_ref),
    .core_tgt(plane_tgt[0]),
    .nb_tgt  (plane_tgt[1]),
    .boot_lvl(boot_lvl)
);

// File: tb/test_vref_sequencer.sv
module test_vref_sequencer;
    localparam int CODE_W = 8;
    localparam int DIV    = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              enable = 1'b0;
    logic [1:0]        boot_sel = 2'b00;
    logic              pwr_ok = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_core = 1'b0;
    logic              cmd_nb = 1'b0;
    logic              cmd_off = 1'b0;
    logic [CODE_W-1:0] cmd_code = '0;
    logic [CODE_W-1:0] core_ref, nb_ref;
    logic              pgood;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #4 clk = ~clk;

    vref_sequencer #(.CODE_W(CODE_W), .TICK_DIV(DIV)) i_vref_sequencer (
        .clk(clk), .rst_n(rst_n), .enable(enable), .boot_sel(boot_sel),
        .pwr_ok(pwr_ok), .cmd_valid(cmd_valid), .cmd_core(cmd_core),
        .cmd_nb(cmd_nb), .cmd_off(cmd_off), .cmd_code(cmd_code),
        .core_ref(core_ref), .nb_ref(nb_ref), .pgood(pgood)
    );

    // {core, nb, off, code, exp_core, exp_nb}
    localparam int VN = 6;
    localparam logic [26:0] VEC [VN] = '{
        {1'b1, 1'b0, 1'b0, 8'd100, 8'd100, 8'd88},
        {1'b0, 1'b1, 1'b0, 8'd60,  8'd100, 8'd60},
        {1'b1, 1'b1, 1'b0, 8'd90,  8'd90,  8'd90},
        {1'b1, 1'b0, 1'b1, 8'd50,  8'd0,   8'd90},
        {1'b1, 1'b1, 1'b1, 8'd70,  8'd0,   8'd70},
        {1'b1, 1'b1, 1'b0, 8'd80,  8'd80,  8'd80}
    };

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input logic c, input logic n, input logic off, input int code);
        cmd_valid = 1'b1; cmd_core = c; cmd_nb = n; cmd_off = off;
        cmd_code = CODE_W'(code);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_core = 1'b0; cmd_nb = 1'b0; cmd_off = 1'b0;
    endtask

    task automatic wait_refs(input int ec, input int en);
        for (int i = 0; i < 5000; i++) begin
            if (core_ref == CODE_W'(ec) && nb_ref == CODE_W'(en)) break;
            @(negedge clk);
        end
    endtask

    task automatic start_up(input logic [1:0] sel);
        boot_sel = sel;
        enable = 1'b1;
        @(negedge clk);
        boot_sel = ~sel;  // R2: changes after capture must be ignored
    endtask

    initial begin
        int gap;
        int mx;
        int boot;
        logic [CODE_W-1:0] prev;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset core", core_ref, 0);
        check("R1 reset nb", nb_ref, 0);
        check("R1 reset pgood", pgood, 0);

        // Boot 01, tick spacing, pgood timing, ignored early command
        start_up(2'b01);
        prev = core_ref;
        while (core_ref == prev) @(negedge clk);
        prev = core_ref;
        gap = 0;
        while (core_ref == prev) begin @(negedge clk); gap++; end
        check("R3 tick spacing", gap, DIV);
        check("R4 pgood low mid ramp", pgood, 0);
        send(1'b1, 1'b1, 1'b0, 120);  // R5: ignored during soft-start
        wait_refs(80, 80);
        check("R2 boot 01 core", core_ref, 80);
        check("R2 boot 01 nb", nb_ref, 80);
        check("R4 pgood low at arrival edge", pgood, 0);
        @(negedge clk);
        check("R4 pgood one clock later", pgood, 1);

        // Other boot codes
        for (int s = 2; s < 5; s++) begin
            enable = 1'b0;
            @(negedge clk);
            check("R1 enable low core", core_ref, 0);
            check("R1 enable low pgood", pgood, 0);
            boot = 88 - 8 * (s % 4);
            start_up(2'(s % 4));
            wait_refs(boot, boot);
            @(negedge clk);
            check("R2 boot core level", core_ref, boot);
            check("R2 boot nb level", nb_ref, boot);
            check("R4 pgood after ramp", pgood, 1);
        end

        // Command with pwr_ok low before any handshake
        send(1'b1, 1'b1, 1'b0, 30);
        repeat (100) @(negedge clk);
        check("R5 cmd before pwr_ok core", core_ref, 88);
        check("R5 cmd before pwr_ok nb", nb_ref, 88);
        pwr_ok = 1'b1;
        repeat (2) @(negedge clk);

        // Vector table walk
        for (int v = 0; v < VN; v++) begin
            send(VEC[v][26], VEC[v][25], VEC[v][24], int'(VEC[v][23:16]));
            wait_refs(int'(VEC[v][15:8]), int'(VEC[v][7:0]));
            check(VEC[v][24] ? "R7 off vector core" : "R6 vector core",
                  core_ref, int'(VEC[v][15:8]));
            check(VEC[v][24] ? "R7 off vector nb" : "R6 vector nb",
                  nb_ref, int'(VEC[v][7:0]));
            check("R11 pgood during commands", pgood, 1);
        end

        // pwr_ok drop: return to boot, commands ignored
        pwr_ok = 1'b0;
        @(negedge clk);
        send(1'b1, 1'b1, 1'b0, 20);
        wait_refs(88, 88);
        send(1'b1, 1'b0, 1'b1, 20);
        repeat (60) @(negedge clk);
        check("R8 back to boot core", core_ref, 88);
        check("R8 back to boot nb", nb_ref, 88);
        check("R8 pgood kept", pgood, 1);
        pwr_ok = 1'b1;
        repeat (200) @(negedge clk);
        check("R9 hold after reassert core", core_ref, 88);
        check("R9 hold after reassert nb", nb_ref, 88);

        // Mid-ramp retarget
        send(1'b1, 1'b0, 1'b0, 120);
        while (core_ref != 8'd95) @(negedge clk);
        send(1'b1, 1'b0, 1'b0, 90);
        mx = 0;
        for (int i = 0; i < 200; i++) begin
            if (int'(core_ref) > mx) mx = int'(core_ref);
            @(negedge clk);
        end
        check("R10 retarget no overshoot", (mx <= 96) ? 1 : 0, 1);
        check("R10 retarget reached", core_ref, 90);
        check("R10 nb untouched", nb_ref, 88);

        enable = 1'b0;
        @(negedge clk);
        check("R1 final core", core_ref, 0);
        check("R1 final nb", nb_ref, 0);
        check("R1 final pgood", pgood, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule